// File: doc/BRIEF.md
# Triple-Access Mirrored RAM

This block offers three access points into one logical memory by keeping two identical copies of the storage. A CPU data port reads and writes. A CPU instruction-fetch port and an integrity-scanner port only read. Each copy is a true dual-port bank. The data port drives the write side of both banks, so every store lands in both copies in the same cycle. Fetches are served by the primary copy and scanner reads by the mirror copy. As a result, any word the CPU writes, including a tampered instruction, is seen by the scanner exactly as the fetch path would see it.

Both copies power up holding the same computed image. All reads are synchronous with one cycle of latency. When a read and a write hit the same word in the same cycle, the read returns the word as it was before the write.

Top module: `tri_port_ram`

## Requirements
- R1: While `rst_n` is low, and after release until the first enabled read on a port, `d_rdata`, `i_rdata` and `s_rdata` are all zero.
- R2: A read enabled on any port in cycle t (`d_en`, `i_en` or `s_en` high at the rising edge) presents the addressed word on that port's read output after that edge, so it is valid throughout cycle t+1.
- R3: A port whose enable is low at a rising edge keeps its read output unchanged.
- R4: A write (`d_en` and `d_we` high) updates byte lane k (bits 8k+7..8k) of the addressed word only where `d_be[k]` is 1. The other lanes keep their value.
- R5: Every data-port write is applied to both copies, so a later fetch read and a later scanner read of that address return the same new word.
- R6: A read on any port that targets the word being written in the same cycle returns the old word. The new word is visible from the next read on.
- R7: At power-up, with the default 32-bit width and 8-bit address, the word at address a is {a,a,a,a} XOR 32'h5A3CC3A5 in both copies.
- R8: The fetch and scanner ports serve different addresses in the same cycle independently, and reading them never changes memory contents.
- R9: `d_we` has no effect while `d_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| d_en | input | 1 | Data port access enable |
| d_we | input | 1 | Data port write select (qualified by d_en) |
| d_be | input | DATA_W/8 | Data port byte-lane write strobes |
| d_addr | input | ADDR_W | Data port word address |
| d_wdata | input | DATA_W | Data port write word |
| d_rdata | output | DATA_W | Data port read word (primary copy) |
| i_en | input | 1 | Fetch port read enable |
| i_addr | input | ADDR_W | Fetch port word address |
| i_rdata | output | DATA_W | Fetch port read word (primary copy) |
| s_en | input | 1 | Scanner port read enable |
| s_addr | input | ADDR_W | Scanner port word address |
| s_rdata | output | DATA_W | Scanner port read word (mirror copy) |

## Verification
Every read result is due one rising edge after the cycle that requested it. A write affects reads from the cycle after its edge on. Held outputs are due unchanged at that same edge. The bench drives inputs at the falling edge, pushes one expected word per port per cycle into a scoreboard queue computed from a bench-side memory model (read before write), and its monitor pops and compares those words a quarter period after the following rising edge. A word driven in a cycle is therefore never compared against the output of the same cycle.

// File: rtl/tpr_pkg.sv
package tpr_pkg;

  // Power-up word for a given address: address byte replicated, then
  // XORed with a seed. Returned at 64 bits; callers truncate.
  function automatic logic [63:0] init_word(input int unsigned idx,
                                            input logic [63:0] seed);
    logic [7:0] lo;
    lo = idx[7:0];
    return {8{lo}} ^ seed;
  endfunction

endpackage

// File: rtl/tpr_bank.sv
module tpr_bank #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [63:0] INIT_SEED = 64'h5A3C_C3A5_5A3C_C3A5,
  parameter bit          A_READ    = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   a_rd_en,
  input  logic                   a_we,
  input  logic [DATA_W/8-1:0]    a_be,
  input  logic [ADDR_W-1:0]      a_addr,
  input  logic [DATA_W-1:0]      a_wdata,
  output logic [DATA_W-1:0]      a_rdata,
  input  logic                   b_en,
  input  logic [ADDR_W-1:0]      b_addr,
  output logic [DATA_W-1:0]      b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] b_rdata_nxt;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(tpr_pkg::init_word(i, INIT_SEED));
    end
  end

  // Port A write with byte strobes
  always_ff @(posedge clk) begin
    if (a_we) begin
      for (int k = 0; k < LANES; k++) begin
        if (a_be[k]) mem[a_addr][k*8 +: 8] <= a_wdata[k*8 +: 8];
      end
    end
  end

  // Port B read: next-state, then register (read-first by construction)
  always_comb begin
    b_rdata_nxt = b_rdata;
    if (b_en) b_rdata_nxt = mem[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_rdata <= '0;
    else        b_rdata <= b_rdata_nxt;
  end

  generate
    if (A_READ) begin : g_a_read
      logic [DATA_W-1:0] a_rdata_nxt;
      logic [DATA_W-1:0] a_rdata_q;

      always_comb begin
        a_rdata_nxt = a_rdata_q;
        if (a_rd_en) a_rdata_nxt = mem[a_addr];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_rdata_q <= '0;
        else        a_rdata_q <= a_rdata_nxt;
      end

      assign a_rdata = a_rdata_q;
    end else begin : g_a_noread
      logic unused_a_rd_en;
      assign unused_a_rd_en = a_rd_en;
      assign a_rdata        = '0;
    end
  endgenerate

endmodule

// File: rtl/tri_port_ram.sv
module tri_port_ram #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [63:0] INIT_SEED = 64'h5A3C_C3A5_5A3C_C3A5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   d_en,
  input  logic                   d_we,
  input  logic [DATA_W/8-1:0]    d_be,
  input  logic [ADDR_W-1:0]      d_addr,
  input  logic [DATA_W-1:0]      d_wdata,
  output logic [DATA_W-1:0]      d_rdata,
  input  logic                   i_en,
  input  logic [ADDR_W-1:0]      i_addr,
  output logic [DATA_W-1:0]      i_rdata,
  input  logic                   s_en,
  input  logic [ADDR_W-1:0]      s_addr,
  output logic [DATA_W-1:0]      s_rdata
);
  logic              wr_go;
  logic [DATA_W-1:0] mirror_a_rdata_unused;

  assign wr_go = d_en & d_we;

  // Primary copy: data port on A (read+write), fetch on B
  tpr_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_SEED(INIT_SEED), .A_READ(1'b1)
  ) u_primary (
    .clk(clk), .rst_n(rst_n),
    .a_rd_en(d_en), .a_we(wr_go), .a_be(d_be), .a_addr(d_addr),
    .a_wdata(d_wdata), .a_rdata(d_rdata),
    .b_en(i_en), .b_addr(i_addr), .b_rdata(i_rdata)
  );

  // Mirror copy: same writes on A (no read), scanner on B
  tpr_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_SEED(INIT_SEED), .A_READ(1'b0)
  ) u_mirror (
    .clk(clk), .rst_n(rst_n),
    .a_rd_en(1'b0), .a_we(wr_go), .a_be(d_be), .a_addr(d_addr),
    .a_wdata(d_wdata), .a_rdata(mirror_a_rdata_unused),
    .b_en(s_en), .b_addr(s_addr), .b_rdata(s_rdata)
  );

endmodule

// File: rtl/tpr_checker.sv
module tpr_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                d_en,
  input logic                d_we,
  input logic [DATA_W/8-1:0] d_be,
  input logic [ADDR_W-1:0]   d_addr,
  input logic [DATA_W-1:0]   d_wdata,
  input logic [DATA_W-1:0]   d_rdata,
  input logic                i_en,
  input logic [ADDR_W-1:0]   i_addr,
  input logic [DATA_W-1:0]   i_rdata,
  input logic                s_en,
  input logic [ADDR_W-1:0]   s_addr,
  input logic [DATA_W-1:0]   s_rdata
);

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (d_rdata == '0 && i_rdata == '0 && s_rdata == '0));

  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !i_en |=> $stable(i_rdata));

  p_scan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> $stable(s_rdata));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !d_en |=> $stable(d_rdata));

  p_copies_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_en && s_en && i_addr == s_addr) |=> (i_rdata == s_rdata));

  p_write_mirrored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && $past(d_en && d_we && (&d_be)) && s_addr == $past(d_addr))
      |=> (s_rdata == $past(d_wdata, 2)));

  p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_en && i_en && d_addr == i_addr) |=> (d_rdata == i_rdata));

endmodule

bind tri_port_ram tpr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .d_en(d_en), .d_we(d_we), .d_be(d_be),
  .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
  .i_en(i_en), .i_addr(i_addr), .i_rdata(i_rdata),
  .s_en(s_en), .s_addr(s_addr), .s_rdata(s_rdata)
);

// File: tb/tri_port_ram_bench.sv
`timescale 1ns/1ps
module tri_port_ram_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          d_en, d_we, i_en, s_en;
  logic [3:0]    d_be;
  logic [AW-1:0] d_addr, i_addr, s_addr;
  logic [DW-1:0] d_wdata, d_rdata, i_rdata, s_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [DW-1:0] model [256];
  logic [DW-1:0] last_q [3];

  int            q_port [$];
  logic [DW-1:0] q_exp  [$];
  string         q_tag  [$];

  tri_port_ram u_tri_port_ram (
    .clk(clk), .rst_n(rst_n),
    .d_en(d_en), .d_we(d_we), .d_be(d_be), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rdata(d_rdata),
    .i_en(i_en), .i_addr(i_addr), .i_rdata(i_rdata),
    .s_en(s_en), .s_addr(s_addr), .s_rdata(s_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, pushes expected words for all ports
  task automatic cyc(input string tag, input bit de, input bit dw,
                     input logic [3:0] be, input int da, input logic [DW-1:0] wd,
                     input bit ie, input int ia, input bit se, input int sa);
    logic [DW-1:0] e_d, e_i, e_s;
    @(negedge clk);
    d_en = de; d_we = dw; d_be = be; d_addr = AW'(da); d_wdata = wd;
    i_en = ie; i_addr = AW'(ia); s_en = se; s_addr = AW'(sa);
    e_d = de ? model[da] : last_q[0];
    e_i = ie ? model[ia] : last_q[1];
    e_s = se ? model[sa] : last_q[2];
    last_q[0] = e_d; last_q[1] = e_i; last_q[2] = e_s;
    q_port.push_back(0); q_exp.push_back(e_d); q_tag.push_back(tag);
    q_port.push_back(1); q_exp.push_back(e_i); q_tag.push_back(tag);
    q_port.push_back(2); q_exp.push_back(e_s); q_tag.push_back(tag);
    if (de && dw) begin
      for (int k = 0; k < 4; k++)
        if (be[k]) model[da][k*8 +: 8] = wd[k*8 +: 8];
    end
  endtask

  task automatic idle();
    cyc("R3", 0, 0, 4'h0, 0, '0, 0, 0, 0, 0);
  endtask

  // Monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q_port.size() > 0) begin
        int p;
        logic [DW-1:0] e;
        string t;
        p = q_port.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        case (p)
          0: check(t, "d_rdata", d_rdata, e);
          1: check(t, "i_rdata", i_rdata, e);
          default: check(t, "s_rdata", s_rdata, e);
        endcase
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      logic [7:0] ab;
      ab = 8'(a);
      model[a] = {ab, ab, ab, ab} ^ 32'h5A3C_C3A5;   // R7 image
    end
    for (int p = 0; p < 3; p++) last_q[p] = '0;
    rst_n = 1'b0; d_en = 0; d_we = 0; d_be = '0; d_addr = '0; d_wdata = '0;
    i_en = 0; i_addr = '0; s_en = 0; s_addr = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R1", "d_rdata in reset", d_rdata, '0);
    check("R1", "i_rdata in reset", i_rdata, '0);
    check("R1", "s_rdata in reset", s_rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();                                   // R1 zero held after release

    // R7 / R2: power-up image on every port
    cyc("R7", 1, 0, 4'h0, 0,   '0, 1, 1,   1, 255);
    cyc("R7", 1, 0, 4'h0, 128, '0, 1, 77,  1, 200);
    cyc("R2", 1, 0, 4'h0, 3,   '0, 1, 4,   1, 5);
    idle(); idle();                                   // R3 hold

    // R5: full write then read back from both copies
    cyc("R5", 1, 1, 4'hF, 40, 32'hDEAD_BEEF, 0, 0, 0, 0);
    cyc("R5", 1, 0, 4'h0, 40, '0, 1, 40, 1, 40);
    // R4: partial strobes
    cyc("R4", 1, 1, 4'b0101, 41, 32'h1122_3344, 0, 0, 0, 0);
    cyc("R4", 1, 1, 4'b1000, 42, 32'hAB00_0000, 0, 0, 0, 0);
    cyc("R4", 1, 0, 4'h0, 41, '0, 1, 41, 1, 42);
    cyc("R4", 0, 0, 4'h0, 0, '0, 1, 42, 1, 41);
    // R6: write and reads on the same word in one cycle
    cyc("R6", 1, 1, 4'hF, 9, 32'h0BAD_F00D, 1, 9, 1, 9);
    cyc("R6", 1, 0, 4'h0, 9, '0, 1, 9, 1, 9);
    // R9: write select without enable
    cyc("R9", 0, 1, 4'hF, 12, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cyc("R9", 1, 0, 4'h0, 12, '0, 1, 12, 1, 12);
    // R8: independent addresses, reads leave contents alone
    cyc("R8", 0, 0, 4'h0, 0, '0, 1, 40, 1, 9);
    cyc("R8", 0, 0, 4'h0, 0, '0, 1, 9,  1, 40);
    cyc("R8", 1, 0, 4'h0, 250, '0, 1, 251, 1, 252);
    // R3: single-port enables, others hold
    cyc("R3", 0, 0, 4'h0, 0, '0, 1, 100, 0, 0);
    cyc("R3", 0, 0, 4'h0, 0, '0, 0, 0,   1, 101);
    idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule